// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block keeps track of the power mode the chip is in and moves it between seven modes: normal run, wait, stop, low-power run, low-power wait, low-power stop and leakage stop. A mode changes when one of these happens: software writes the control fields, the processor issues a sleep request (with or without its deep-sleep flag), or an interrupt, wakeup-unit event or reset-pin event arrives. Clocks, regulators, frequency limits and the logic that picks wakeup sources belong to other blocks. This block only decides and reports the mode.

Two permission bits must be set before the low-power modes can be entered. The permission register takes one write after each system reset. After that it is frozen. A request that is not permitted, or that names a stop-mode encoding with no meaning, is dropped and the mode does not change. Low-power stop can be entered from normal run or from low-power run. The block records which one it came from, because the wake-up exit goes back to that origin.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: After system reset (`rst_n` low), `mode_code` is 0 (RUN), `mode_chg` is 0 and `prot_rd` is 0.
- R2: In RUN, `sleep_req` with `sleep_deep` = 0 enters WAIT. With `sleep_deep` = 1, stop field 3'b000 and run field 2'b00, it enters STOP. An `irq` in WAIT or STOP returns to RUN.
- R3: A control write with run field 2'b10 while in RUN enters VLPR only if `prot_rd[0]` is 1. A control write with run field 2'b00 while in VLPR returns to RUN.
- R4: In VLPR, `sleep_req` with `sleep_deep` = 0 enters VLPW, and an `irq` in VLPW returns to VLPR.
- R5: In VLPR, a deep sleep with stop field 3'b000 or 3'b010 enters VLPS. An `irq` then returns to VLPR.
- R6: In RUN, a deep sleep with stop field 3'b010 and `prot_rd[0]` = 1 enters VLPS. An `irq` then returns to RUN and not to VLPR.
- R7: In RUN or VLPR, a deep sleep with stop field 3'b100 and `prot_rd[1]` = 1 enters VLLS. `leak_variant` then shows the leakage field that was written last.
- R8: In VLLS an `irq` is ignored. A `wake_evt` returns to RUN.
- R9: A deep sleep whose permission bit is clear, or whose stop field is any value other than those named in R2, R5, R6 and R7, leaves the mode unchanged.
- R10: The permission register takes only the first `prot_wr` after system reset. Later writes leave `prot_rd` unchanged.
- R11: `pin_rst` returns any mode to RUN and takes priority over every other event.
- R12: `mode_code` changes on the first rising edge that samples the causing event. `mode_chg` is 1 in exactly the cycles in which `mode_code` has just changed. The mode codes are RUN 0, WAIT 1, STOP 2, VLPR 3, VLPW 4, VLPS 5 and VLLS 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prot_wr | input | 1 | Permission register write strobe |
| prot_wdata | input | 2 | Bit 0 allows low-power modes, bit 1 allows leakage stop |
| prot_rd | output | 2 | Permission register contents |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_run_sel | input | 2 | Run field: 00 normal, 10 low-power |
| ctrl_stop_sel | input | 3 | Stop field: 000 stop, 010 low-power stop, 100 leakage stop |
| ctrl_leak_sel | input | 2 | Leakage stop variant |
| sleep_req | input | 1 | Processor sleep request strobe |
| sleep_deep | input | 1 | Deep-sleep flag qualifying `sleep_req` |
| irq | input | 1 | Interrupt |
| wake_evt | input | 1 | Enabled wakeup-unit event |
| pin_rst | input | 1 | Reset-pin event |
| mode_code | output | 3 | Current mode |
| mode_chg | output | 1 | Mode changed at the last edge |
| leak_variant | output | 2 | Variant latched on leakage stop entry |

## Verification
Every event is applied as a single-cycle strobe that is set up half a period before a rising edge. The mode, the change flag and the latched variant are therefore due on that same edge and are read at the falling edge that follows. Permission readback follows the same one-edge rule. Field writes take one edge to land before a sleep request can use them, so the bench leaves a full cycle between each write and the request that relies on it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int LLW = 2;
    localparam int RSW = 2;
    localparam int SSW = 3;

    typedef enum logic [2:0] {
        M_RUN  = 3'd0,
        M_WAIT = 3'd1,
        M_STOP = 3'd2,
        M_VLPR = 3'd3,
        M_VLPW = 3'd4,
        M_VLPS = 3'd5,
        M_VLLS = 3'd6
    } mode_e;

    localparam logic [RSW-1:0] RS_NORMAL = 2'b00;
    localparam logic [RSW-1:0] RS_LOWPWR = 2'b10;
    localparam logic [SSW-1:0] SS_STOP   = 3'b000;
    localparam logic [SSW-1:0] SS_LPSTOP = 3'b010;
    localparam logic [SSW-1:0] SS_LEAK   = 3'b100;

    typedef struct packed {
        mode_e          mode;
        logic           from_run;
        logic [LLW-1:0] variant;
        logic           chg;
    } state_t;

endpackage

// File: rtl/pmc_prot_reg.sv
module pmc_prot_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic [1:0] prot
);
    typedef struct packed {
        logic [1:0] bits;
        logic       locked;
    } prot_t;

    prot_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr && !reg_q.locked) begin
            reg_d.bits   = wdata;
            reg_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign prot = reg_q.bits;

    AST_PROT_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.locked && wr) |=> $stable(prot)); // R10

endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [RSW-1:0] run_in,
    input  logic [SSW-1:0] stop_in,
    input  logic [LLW-1:0] leak_in,
    output logic [RSW-1:0] run_q,
    output logic [SSW-1:0] stop_q,
    output logic [LLW-1:0] leak_q
);
    typedef struct packed {
        logic [RSW-1:0] run;
        logic [SSW-1:0] stop;
        logic [LLW-1:0] leak;
    } fields_t;

    fields_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (wr) begin
            f_d.run  = run_in;
            f_d.stop = stop_in;
            f_d.leak = leak_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign run_q  = f_q.run;
    assign stop_q = f_q.stop;
    assign leak_q = f_q.leak;

endmodule

// File: rtl/pmc_next_mode.sv
module pmc_next_mode
    import pmc_pkg::*;
(
    input  mode_e          cur,
    input  logic           cur_from_run,
    input  logic           allow_lp,
    input  logic           allow_leak,
    input  logic           wr,
    input  logic [RSW-1:0] wr_run,
    input  logic [RSW-1:0] run_q,
    input  logic [SSW-1:0] stop_q,
    input  logic           sleep_req,
    input  logic           sleep_deep,
    input  logic           irq,
    input  logic           wake_evt,
    input  logic           pin_rst,
    output mode_e          nxt,
    output logic           nxt_from_run,
    output logic           load_variant
);
    always_comb begin
        nxt          = cur;
        nxt_from_run = cur_from_run;
        load_variant = 1'b0;
        if (pin_rst) begin
            nxt          = M_RUN;
            nxt_from_run = 1'b0;
        end else begin
            case (cur)
                M_RUN: begin
                    if (wr) begin
                        if (wr_run == RS_LOWPWR && allow_lp) nxt = M_VLPR;
                    end else if (sleep_req) begin
                        if (!sleep_deep) begin
                            nxt = M_WAIT;
                        end else if (stop_q == SS_STOP && run_q == RS_NORMAL) begin
                            nxt = M_STOP;
                        end else if (stop_q == SS_LPSTOP && allow_lp) begin
                            nxt          = M_VLPS;
                            nxt_from_run = 1'b1;
                        end else if (stop_q == SS_LEAK && allow_leak) begin
                            nxt          = M_VLLS;
                            load_variant = 1'b1;
                        end
                    end
                end
                M_WAIT, M_STOP: begin
                    if (irq) nxt = M_RUN;
                end
                M_VLPR: begin
                    if (wr) begin
                        if (wr_run == RS_NORMAL) nxt = M_RUN;
                    end else if (sleep_req) begin
                        if (!sleep_deep) begin
                            nxt = M_VLPW;
                        end else if (stop_q == SS_STOP || stop_q == SS_LPSTOP) begin
                            nxt          = M_VLPS;
                            nxt_from_run = 1'b0;
                        end else if (stop_q == SS_LEAK && allow_leak) begin
                            nxt          = M_VLLS;
                            load_variant = 1'b1;
                        end
                    end
                end
                M_VLPW: begin
                    if (irq) nxt = M_VLPR;
                end
                M_VLPS: begin
                    if (irq) begin
                        nxt          = cur_from_run ? M_RUN : M_VLPR;
                        nxt_from_run = 1'b0;
                    end
                end
                M_VLLS: begin
                    if (wake_evt) nxt = M_RUN;
                end
                default: nxt = M_RUN;
            endcase
        end
    end

endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
    import pmc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prot_wr,
    input  logic [1:0]     prot_wdata,
    output logic [1:0]     prot_rd,
    input  logic           ctrl_wr,
    input  logic [RSW-1:0] ctrl_run_sel,
    input  logic [SSW-1:0] ctrl_stop_sel,
    input  logic [LLW-1:0] ctrl_leak_sel,
    input  logic           sleep_req,
    input  logic           sleep_deep,
    input  logic           irq,
    input  logic           wake_evt,
    input  logic           pin_rst,
    output logic [2:0]     mode_code,
    output logic           mode_chg,
    output logic [LLW-1:0] leak_variant
);
    logic [1:0]     prot;
    logic [RSW-1:0] run_q;
    logic [SSW-1:0] stop_q;
    logic [LLW-1:0] leak_q;
    mode_e          nxt;
    logic           nxt_from_run;
    logic           load_variant;
    state_t         st_d, st_q;

    pmc_prot_reg u_prot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (prot_wr),
        .wdata (prot_wdata),
        .prot  (prot)
    );

    pmc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .run_in  (ctrl_run_sel),
        .stop_in (ctrl_stop_sel),
        .leak_in (ctrl_leak_sel),
        .run_q   (run_q),
        .stop_q  (stop_q),
        .leak_q  (leak_q)
    );

    pmc_next_mode u_next (
        .cur          (st_q.mode),
        .cur_from_run (st_q.from_run),
        .allow_lp     (prot[0]),
        .allow_leak   (prot[1]),
        .wr           (ctrl_wr),
        .wr_run       (ctrl_run_sel),
        .run_q        (run_q),
        .stop_q       (stop_q),
        .sleep_req    (sleep_req),
        .sleep_deep   (sleep_deep),
        .irq          (irq),
        .wake_evt     (wake_evt),
        .pin_rst      (pin_rst),
        .nxt          (nxt),
        .nxt_from_run (nxt_from_run),
        .load_variant (load_variant)
    );

    always_comb begin
        st_d          = st_q;
        st_d.mode     = nxt;
        st_d.from_run = nxt_from_run;
        st_d.chg      = (nxt != st_q.mode);
        if (load_variant) st_d.variant = leak_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_RUN, from_run: 1'b0, variant: '0, chg: 1'b0};
        else        st_q <= st_d;
    end

    assign prot_rd      = prot;
    assign mode_code    = st_q.mode;
    assign mode_chg     = st_q.chg;
    assign leak_variant = st_q.variant;

    AST_PIN_RST_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rst |=> (mode_code == 3'd0)); // R11

    AST_LEAK_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd6 && irq && !wake_evt && !pin_rst) |=> (mode_code == 3'd6)); // R8

    AST_LEAK_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd6 && wake_evt && !pin_rst) |=> (mode_code == 3'd0)); // R8

    AST_DIRECT_LPSTOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd5 && st_q.from_run && irq && !pin_rst) |=> (mode_code == 3'd0)); // R6

    AST_LPRUN_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_code == 3'd3 && $past(mode_code) == 3'd0) |-> $past(prot_rd[0])); // R3

    AST_LEAK_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_code == 3'd6) |-> $past(prot_rd[1])); // R7

    AST_CHG_MEANS_NEW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> (mode_code != $past(mode_code))); // R12

    AST_NO_CHG_MEANS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg |-> $stable(mode_code)); // R12

    AST_MODE_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code != 3'd7); // R12

endmodule

// File: tb/test_pmc_mode_ctrl.sv
`timescale 1ns/1ps
module test_pmc_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prot_wr = 1'b0;
    logic [1:0] prot_wdata = '0;
    logic [1:0] prot_rd;
    logic       ctrl_wr = 1'b0;
    logic [1:0] ctrl_run_sel = '0;
    logic [2:0] ctrl_stop_sel = '0;
    logic [1:0] ctrl_leak_sel = '0;
    logic       sleep_req = 1'b0;
    logic       sleep_deep = 1'b0;
    logic       irq = 1'b0;
    logic       wake_evt = 1'b0;
    logic       pin_rst = 1'b0;
    logic [2:0] mode_code;
    logic       mode_chg;
    logic [1:0] leak_variant;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    pmc_mode_ctrl i_pmc_mode_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .prot_wr       (prot_wr),
        .prot_wdata    (prot_wdata),
        .prot_rd       (prot_rd),
        .ctrl_wr       (ctrl_wr),
        .ctrl_run_sel  (ctrl_run_sel),
        .ctrl_stop_sel (ctrl_stop_sel),
        .ctrl_leak_sel (ctrl_leak_sel),
        .sleep_req     (sleep_req),
        .sleep_deep    (sleep_deep),
        .irq           (irq),
        .wake_evt      (wake_evt),
        .pin_rst       (pin_rst),
        .mode_code     (mode_code),
        .mode_chg      (mode_chg),
        .leak_variant  (leak_variant)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobes set before the call are sampled at the next rising edge;
    // returns at the following falling edge with strobes cleared.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        prot_wr = 1'b0; ctrl_wr = 1'b0; sleep_req = 1'b0;
        irq = 1'b0; wake_evt = 1'b0; pin_rst = 1'b0;
    endtask

    task automatic ctrl_write(input logic [1:0] rs, input logic [2:0] ss, input logic [1:0] ls);
        ctrl_wr = 1'b1; ctrl_run_sel = rs; ctrl_stop_sel = ss; ctrl_leak_sel = ls;
        tick();
    endtask

    function automatic int exp_sleep(int from, int deep, int ss, int alp, int alk);
        if (from == 0) begin
            if (deep == 0) return 1;
            if (ss == 0) return 2;
            if (ss == 2 && alp == 1) return 5;
            if (ss == 4 && alk == 1) return 6;
            return 0;
        end
        if (deep == 0) return 4;
        if (ss == 0 || ss == 2) return 5;
        if (ss == 4 && alk == 1) return 6;
        return 3;
    endfunction

    function automatic int exp_irq(int m, int origin_run);
        if (m == 1 || m == 2) return 0;
        if (m == 4) return 3;
        if (m == 5) return (origin_run == 1) ? 0 : 3;
        return m;
    endfunction

    task automatic sweep(input int alp, input int alk);
        for (int from_i = 0; from_i < 2; from_i++) begin
            for (int deep = 0; deep < 2; deep++) begin
                for (int ss = 0; ss < 8; ss++) begin
                    int from = (from_i == 0) ? 0 : 3;
                    int e;
                    int lv;
                    if (from == 3 && alp == 0) continue;
                    lv = (ss + 1) % 4;
                    pin_rst = 1'b1;
                    tick();
                    chk("R11 pin reset to RUN", mode_code, 0);
                    if (from == 3) begin
                        ctrl_write(2'b10, 3'(ss), 2'(lv));
                        chk("R3 enter VLPR", mode_code, 3);
                        chk("R12 change flag on VLPR entry", mode_chg, 1);
                    end else begin
                        ctrl_write(2'b00, 3'(ss), 2'(lv));
                    end
                    sleep_req = 1'b1; sleep_deep = deep[0];
                    tick();
                    e = exp_sleep(from, deep, ss, alp, alk);
                    chk((e == from) ? "R9 blocked sleep keeps mode" :
                        (e == 6) ? "R7 enter VLLS" :
                        (e == 5) ? "R5 R6 enter VLPS" : "R2 R4 sleep entry",
                        mode_code, e);
                    chk("R12 change flag after sleep", mode_chg, (e != from) ? 1 : 0);
                    if (e == 6) chk("R7 leak variant latched", leak_variant, lv);
                    irq = 1'b1;
                    tick();
                    chk((e == 6) ? "R8 VLLS ignores irq" :
                        (e == 5 && from == 0) ? "R6 direct VLPS exits to RUN" :
                        (e == 5) ? "R5 VLPS exits to VLPR" : "R2 R4 irq exit",
                        mode_code, exp_irq(e, (from == 0) ? 1 : 0));
                    if (e == 6) begin
                        wake_evt = 1'b1;
                        tick();
                        chk("R8 wake exits VLLS", mode_code, 0);
                    end
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mode", mode_code, 0);
        chk("R1 reset change flag", mode_chg, 0);
        chk("R1 reset permissions", prot_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // No permissions: low-power run request ignored, sleep sweep from RUN.
        ctrl_write(2'b10, 3'b000, 2'b00);
        chk("R3 VLPR blocked without permit", mode_code, 0);
        chk("R9 no change flag when blocked", mode_chg, 0);
        sweep(0, 0);

        // System reset, then grant both permissions.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset returns RUN", mode_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        prot_wr = 1'b1; prot_wdata = 2'b11;
        tick();
        chk("R10 first permission write", prot_rd, 3);
        prot_wr = 1'b1; prot_wdata = 2'b00;
        tick();
        chk("R10 second write ignored", prot_rd, 3);
        sweep(1, 1);

        // VLPR to RUN via run field write.
        ctrl_write(2'b10, 3'b000, 2'b00);
        chk("R3 enter VLPR", mode_code, 3);
        ctrl_write(2'b00, 3'b000, 2'b00);
        chk("R3 VLPR write 00 returns RUN", mode_code, 0);
        chk("R12 change flag on exit", mode_chg, 1);
        tick();
        chk("R12 change flag drops", mode_chg, 0);

        // Reset-pin priority over wake and irq in VLPW.
        ctrl_write(2'b10, 3'b000, 2'b00);
        sleep_req = 1'b1; sleep_deep = 1'b0;
        tick();
        chk("R4 enter VLPW", mode_code, 4);
        pin_rst = 1'b1; irq = 1'b1;
        tick();
        chk("R11 pin reset wins over irq", mode_code, 0);

        // Permission only for leakage: low-power stop from RUN blocked.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        prot_wr = 1'b1; prot_wdata = 2'b10;
        tick();
        chk("R10 partial permission", prot_rd, 2);
        ctrl_write(2'b00, 3'b010, 2'b01);
        sleep_req = 1'b1; sleep_deep = 1'b1;
        tick();
        chk("R9 VLPS blocked without permit", mode_code, 0);
        ctrl_write(2'b00, 3'b100, 2'b10);
        sleep_req = 1'b1; sleep_deep = 1'b1;
        tick();
        chk("R7 VLLS with leak permit only", mode_code, 6);
        chk("R7 variant value", leak_variant, 2);
        pin_rst = 1'b1;
        tick();
        chk("R11 pin reset exits VLLS", mode_code, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule